// File: doc/BRIEF.md
# I2C Sequencer Control Register Decoder

This block sits between a control-register write port and a command-driven I2C master. Every write carries several independent fields. One field pulses a timed reset of the command queues. One starts or stops the sequencer. One sets how many command bytes follow the slave address. The low byte either sets the quarter-bit timing of the bit engine or, when its value is too small to be a usable delay, drives the SCL and SDA lines directly. Software uses direct drive, for example, to clock a stuck slave free while the sequencer is stopped.

A stop request does not cut a transfer short. The sequencer keeps running until the bit engine reports an idle bus, and then it halts. The pin-drive outputs are open-drain style enable/value pairs. A released line has its enable low. Direct drive is refused for as long as the sequencer is running, and that includes the time during which a stop request is waiting for an idle bus.

Top module: `i2c_ctl_decoder`

## Requirements
- R1: After reset, running=0, fifoReset=0, status=0, cmdBytes=0, quarterDelay=DEFAULT_DELAY (default 50), and both lines are released (drive enable 0, drive value 1).
- R2: A write with bit 14 set raises fifoReset for exactly RESET_CYCLES (default 16) cycles, starting at the clock edge of the write. The same edge clears running and cancels a waiting stop. A further bit-14 write during the reset restarts the count.
- R3: A write with bits [13:12]=3 sets running at its edge, unless that write also has bit 14 set or a reset is already in progress. Values 0 and 1 leave the run state unchanged.
- R4: A write with bits [13:12]=2 while running requests a stop. running clears at the first edge, counting the write's own edge, at which busIdle is high with the stop requested. A start command cancels a waiting stop.
- R5: A write with bit 11 set loads cmdBytes from bits [10:9]. A write with bit 11 clear leaves cmdBytes unchanged.
- R6: A write whose bits [7:4] are not all zero loads quarterDelay from bits [7:0] and leaves both line drives unchanged.
- R7: A write whose bits [7:4] are zero is a pin-drive write. Bits [1:0] set the SCL code and bits [3:2] set the SDA code. Code 0 keeps the line as it is, 1 drives it low (enable 1, value 0), 2 drives it high (enable 1, value 1), and 3 releases it (enable 0, value 1). quarterDelay is unchanged.
- R8: Pin-drive writes have no effect while running is 1, which includes the time a stop is waiting for an idle bus.
- R9: status[0] equals the run state and status[1] is high while the queue reset is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 16 | Control register write data |
| busIdle | input | 1 | Bit engine reports the bus at an idle point |
| running | output | 1 | Sequencer run state |
| fifoReset | output | 1 | Command queue reset, held for RESET_CYCLES |
| status | output | 2 | {reset in progress, running} |
| cmdBytes | output | 2 | Command bytes sent after the slave address |
| quarterDelay | output | 8 | Quarter I2C bit period in clocks |
| sclDriveEn | output | 1 | SCL drive enable (0 = released) |
| sclDriveVal | output | 1 | SCL driven value |
| sdaDriveEn | output | 1 | SDA drive enable (0 = released) |
| sdaDriveVal | output | 1 | SDA driven value |

## Verification
The assertions check on every cycle the following properties. The reset pulse has the exact length from its last trigger. The run state falls only after an idle bus or a queue reset. The line drives stay frozen whenever the sequencer runs or a delay write arrives. cmdBytes and quarterDelay move only on their own kind of write. Only the bench scenarios show the full decode tables: every pair of previous and new pin code on each line, every run-field value from both run states, and every byte count. They also show the interplay of start commands with a reset in progress, and a stop held off by a busy bus.

// File: rtl/i2cctl_pkg.sv
`timescale 1ns/1ps
package i2cctl_pkg;
  localparam int CTL_W      = 16;
  localparam int DELAY_W    = 8;
  localparam int RESET_BIT  = 14;
  localparam int RUN_HI     = 13;
  localparam int RUN_LO     = 12;
  localparam int BYTES_EN   = 11;
  localparam int BYTES_HI   = 10;
  localparam int BYTES_LO   = 9;
  localparam int NUM_PINS   = 2;

  typedef enum logic [1:0] {
    PIN_KEEP  = 2'd0,
    PIN_LOW   = 2'd1,
    PIN_HIGH  = 2'd2,
    PIN_FLOAT = 2'd3
  } pinCode_t;

  typedef struct packed {
    logic                loadDelay;
    logic                loadBytes;
    logic [NUM_PINS-1:0] loadPin;
  } ctlStrobes_t;
endpackage

// File: rtl/i2cctl_control.sv
`timescale 1ns/1ps
module i2cctl_control
  import i2cctl_pkg::*;
#(
  parameter int RESET_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrData,
  input  logic             busIdle,
  output ctlStrobes_t      strobes,
  output logic             running,
  output logic             resetBusy
);
  localparam int CNT_W = $clog2(RESET_CYCLES + 1);

  logic [CNT_W-1:0] rstCnt;
  logic             stopPending;
  logic             resetReq, startReq, stopReq, pinMode, stopNow;
  logic [1:0]       runField;

  assign runField  = wrData[RUN_HI:RUN_LO];
  assign resetBusy = (rstCnt != '0);
  assign resetReq  = wrEn && wrData[RESET_BIT];
  assign startReq  = wrEn && (runField == 2'd3) && !resetReq && !resetBusy;
  assign stopReq   = wrEn && (runField == 2'd2) && running && !resetReq;
  assign stopNow   = (stopPending || stopReq) && busIdle;
  assign pinMode   = (wrData[DELAY_W-1:4] == '0);

  always_comb begin
    strobes.loadDelay = wrEn && !pinMode;
    strobes.loadBytes = wrEn && wrData[BYTES_EN];
    for (int p = 0; p < NUM_PINS; p++) begin
      strobes.loadPin[p] = wrEn && pinMode && !running && (wrData[2*p +: 2] != 2'd0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rstCnt <= '0;
    end else if (resetReq) begin
      rstCnt <= CNT_W'(RESET_CYCLES);
    end else if (resetBusy) begin
      rstCnt <= rstCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running     <= 1'b0;
      stopPending <= 1'b0;
    end else if (resetReq) begin
      running     <= 1'b0;
      stopPending <= 1'b0;
    end else if (startReq) begin
      running     <= 1'b1;
      stopPending <= 1'b0;
    end else if (stopNow) begin
      running     <= 1'b0;
      stopPending <= 1'b0;
    end else if (stopReq) begin
      stopPending <= 1'b1;
    end
  end
endmodule

// File: rtl/i2cctl_datapath.sv
`timescale 1ns/1ps
module i2cctl_datapath
  import i2cctl_pkg::*;
#(
  parameter logic [DELAY_W-1:0] DEFAULT_DELAY = 8'd50
) (
  input  logic                clk,
  input  logic                rst,
  input  ctlStrobes_t         strobes,
  input  logic [CTL_W-1:0]    wrData,
  output logic [DELAY_W-1:0]  quarterDelay,
  output logic [1:0]          cmdBytes,
  output logic [NUM_PINS-1:0] driveEn,
  output logic [NUM_PINS-1:0] driveVal
);
  always_ff @(posedge clk) begin
    if (rst) begin
      quarterDelay <= DEFAULT_DELAY;
    end else if (strobes.loadDelay) begin
      quarterDelay <= wrData[DELAY_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdBytes <= 2'd0;
    end else if (strobes.loadBytes) begin
      cmdBytes <= wrData[BYTES_HI:BYTES_LO];
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    localparam int LSB = 2 * g;
    pinCode_t pinCode;

    always_ff @(posedge clk) begin
      if (rst) begin
        pinCode <= PIN_FLOAT;
      end else if (strobes.loadPin[g]) begin
        pinCode <= pinCode_t'(wrData[LSB +: 2]);
      end
    end

    assign driveEn[g]  = (pinCode != PIN_FLOAT);
    assign driveVal[g] = (pinCode != PIN_LOW);
  end
endmodule

// File: rtl/i2c_ctl_decoder.sv
`timescale 1ns/1ps
module i2c_ctl_decoder
  import i2cctl_pkg::*;
#(
  parameter int                 RESET_CYCLES  = 16,
  parameter logic [DELAY_W-1:0] DEFAULT_DELAY = 8'd50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        busIdle,
  output logic        running,
  output logic        fifoReset,
  output logic [1:0]  status,
  output logic [1:0]  cmdBytes,
  output logic [7:0]  quarterDelay,
  output logic        sclDriveEn,
  output logic        sclDriveVal,
  output logic        sdaDriveEn,
  output logic        sdaDriveVal
);
  ctlStrobes_t         strobes;
  logic [NUM_PINS-1:0] driveEn, driveVal;

  i2cctl_control #(.RESET_CYCLES(RESET_CYCLES)) u_control (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .busIdle   (busIdle),
    .strobes   (strobes),
    .running   (running),
    .resetBusy (fifoReset)
  );

  i2cctl_datapath #(.DEFAULT_DELAY(DEFAULT_DELAY)) u_datapath (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .wrData       (wrData),
    .quarterDelay (quarterDelay),
    .cmdBytes     (cmdBytes),
    .driveEn      (driveEn),
    .driveVal     (driveVal)
  );

  assign status      = {fifoReset, running};
  assign sclDriveEn  = driveEn[0];
  assign sclDriveVal = driveVal[0];
  assign sdaDriveEn  = driveEn[1];
  assign sdaDriveVal = driveVal[1];
endmodule

// File: rtl/i2cctl_checker.sv
`timescale 1ns/1ps
module i2cctl_checker #(
  parameter int RESET_CYCLES = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic        busIdle,
  input logic        running,
  input logic        fifoReset,
  input logic [1:0]  cmdBytes,
  input logic [7:0]  quarterDelay,
  input logic        sclDriveEn,
  input logic        sclDriveVal,
  input logic        sdaDriveEn,
  input logic        sdaDriveVal
);
  localparam int HC_W = $clog2(RESET_CYCLES + 1) + 1;
  logic [HC_W-1:0] hiCount;
  logic [3:0]      pins;
  assign pins = {sclDriveEn, sclDriveVal, sdaDriveEn, sdaDriveVal};

  always_ff @(posedge clk) begin
    if (rst) hiCount <= '0;
    else if (wrEn && wrData[14]) hiCount <= '0;
    else if (fifoReset) hiCount <= hiCount + 1'b1;
  end

  assert_reset_len_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(fifoReset) |-> (hiCount == HC_W'(RESET_CYCLES)));

  assert_reset_stops_R2: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[14]) |=> (fifoReset && !running));

  assert_start_R3: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[13:12] == 2'd3 && !wrData[14] && !fifoReset) |=> running);

  assert_stop_idle_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> ($past(busIdle) || $past(wrEn && wrData[14])));

  assert_bytes_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && wrData[11]) |=> $stable(cmdBytes));

  assert_delay_load_R6: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[7:4] != 4'd0) |=> (quarterDelay == $past(wrData[7:0])) && $stable(pins));

  assert_delay_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[7:4] == 4'd0) |=> $stable(quarterDelay));

  assert_pins_locked_R8: assert property (@(posedge clk) disable iff (rst)
    running |=> $stable(pins));
endmodule

bind i2c_ctl_decoder i2cctl_checker #(.RESET_CYCLES(RESET_CYCLES)) u_checker (
  .clk          (clk),
  .rst          (rst),
  .wrEn         (wrEn),
  .wrData       (wrData),
  .busIdle      (busIdle),
  .running      (running),
  .fifoReset    (fifoReset),
  .cmdBytes     (cmdBytes),
  .quarterDelay (quarterDelay),
  .sclDriveEn   (sclDriveEn),
  .sclDriveVal  (sclDriveVal),
  .sdaDriveEn   (sdaDriveEn),
  .sdaDriveVal  (sdaDriveVal)
);

// File: tb/test_i2c_ctl_decoder.sv
`timescale 1ns/1ps
module test_i2c_ctl_decoder;
  localparam int RST_LEN = 16;
  localparam int DEF_DLY = 50;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = 16'h0;
  logic        busIdle = 1'b1;
  logic        running, fifoReset;
  logic [1:0]  status, cmdBytes;
  logic [7:0]  quarterDelay;
  logic        sclDriveEn, sclDriveVal, sdaDriveEn, sdaDriveVal;

  int testsRun = 0;
  int testsFailed = 0;
  int expScl = 3;
  int expSda = 3;
  int expDelay = DEF_DLY;

  always #2.5 clk = ~clk;

  i2c_ctl_decoder #(.RESET_CYCLES(RST_LEN), .DEFAULT_DELAY(8'(DEF_DLY))) i_i2c_ctl_decoder (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .busIdle(busIdle),
    .running(running), .fifoReset(fifoReset), .status(status), .cmdBytes(cmdBytes),
    .quarterDelay(quarterDelay), .sclDriveEn(sclDriveEn), .sclDriveVal(sclDriveVal),
    .sdaDriveEn(sdaDriveEn), .sdaDriveVal(sdaDriveVal)
  );

  task automatic check(input string req, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic writeReg(input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = 16'h0;
  endtask

  // en = code != 3, val = code != 1
  task automatic checkPins(input string req);
    check({req, " scl en"}, int'(sclDriveEn), int'(expScl != 3));
    check({req, " scl val"}, int'(sclDriveVal), int'(expScl != 1));
    check({req, " sda en"}, int'(sdaDriveEn), int'(expSda != 3));
    check({req, " sda val"}, int'(sdaDriveVal), int'(expSda != 1));
  endtask

  task automatic waitResetDone();
    for (int k = 0; k < 40 && fifoReset; k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int hiCycles;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 running", int'(running), 0);
    check("R1 fifoReset", int'(fifoReset), 0);
    check("R1 status", int'(status), 0);
    check("R1 cmdBytes", int'(cmdBytes), 0);
    check("R1 delay", int'(quarterDelay), DEF_DLY);
    checkPins("R1");

    // R7 sweep: every previous/new code on SCL, then SDA
    for (int p = 1; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        writeReg(16'(p)); expScl = p;
        writeReg(16'(c)); if (c != 0) expScl = c;
        checkPins("R7 scl");
        check("R7 delay", int'(quarterDelay), expDelay);
      end
    end
    for (int p = 1; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        writeReg(16'(p << 2)); expSda = p;
        writeReg(16'(c << 2)); if (c != 0) expSda = c;
        checkPins("R7 sda");
      end
    end

    // R6 delay sweep, pins untouched
    writeReg(16'h0009); expScl = 1; expSda = 2;
    for (int d = 16; d < 256; d += 37) begin
      writeReg(16'(d)); expDelay = d;
      check("R6 delay", int'(quarterDelay), expDelay);
      checkPins("R6");
    end

    // R5 byte count sweep
    for (int b = 0; b < 4; b++) begin
      writeReg(16'((1 << 11) | (b << 9)));
      check("R5 load", int'(cmdBytes), b);
      writeReg(16'(((3 - b) << 9)));
      check("R5 hold", int'(cmdBytes), b);
    end

    // R3/R4 run field sweep from both states with idle bus
    for (int s = 0; s < 2; s++) begin
      for (int r = 0; r < 4; r++) begin
        writeReg(s ? 16'h3000 : 16'h2000);
        writeReg(16'(r << 12));
        check(r == 2 ? "R4 run field" : "R3 run field", int'(running),
              r == 3 ? 1 : (r == 2 ? 0 : s));
        check("R9 status run", int'(status[0]), int'(running));
      end
    end

    // R2 reset length and stop of a running sequencer
    writeReg(16'h3000);
    writeReg(16'h4000);
    check("R2 stops", int'(running), 0);
    check("R9 status busy", int'(status), 2);
    hiCycles = 0;
    while (fifoReset && hiCycles < 40) begin hiCycles++; @(negedge clk); end
    check("R2 length", hiCycles, RST_LEN);

    // R2 retrigger restarts count
    writeReg(16'h4000);
    repeat (5) @(negedge clk);
    writeReg(16'h4000);
    hiCycles = 0;
    while (fifoReset && hiCycles < 40) begin hiCycles++; @(negedge clk); end
    check("R2 retrigger", hiCycles, RST_LEN);

    // R3 start ignored during reset and on the reset write itself
    writeReg(16'h4000);
    writeReg(16'h3000);
    check("R3 start in reset", int'(running), 0);
    waitResetDone();
    writeReg(16'h7000);
    check("R3 start with reset", int'(running), 0);
    waitResetDone();
    writeReg(16'h3000);
    check("R3 start after reset", int'(running), 1);

    // R8 pins locked while running
    writeReg(16'h0005);
    checkPins("R8 running");

    // R4 stop waits for idle bus; R8 locked while waiting
    @(negedge clk); busIdle = 1'b0;
    writeReg(16'h2000);
    check("R4 held", int'(running), 1);
    repeat (5) @(negedge clk);
    check("R4 still held", int'(running), 1);
    writeReg(16'h000F);
    checkPins("R8 pending");
    busIdle = 1'b1;
    @(negedge clk);
    check("R4 stopped at idle", int'(running), 0);
    writeReg(16'h0006); expScl = 2; expSda = 1;
    checkPins("R8 after stop");

    // R4 start cancels pending stop
    writeReg(16'h3000);
    @(negedge clk); busIdle = 1'b0;
    writeReg(16'h2000);
    writeReg(16'h3000);
    busIdle = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 cancel", int'(running), 1);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule